// File: doc/BRIEF.md
# Configuration Image Header Validator

This block inspects the opening bytes of a configuration image while they stream out of flash, one byte per cycle in which `byteValid` is high. It takes a fixed-length header followed by a two-byte check value and runs a CRC over the header bytes as they pass. It also collects a user code that is spread across the header as the least significant bit of consecutive bytes. When the last check byte arrives, it compares that code with the value on `expectedCode` and settles on a verdict.

The verdict is an accept flag formed from two conditions: the CRC must be good and the user code must match. A system-update controller can therefore refuse an image that has a valid CRC but was built for another instrument. A `start` pulse begins each check, and the verdict holds until the next `start`. The block does not access flash and does not load the rest of the image.

Top module: `hdr_validator`

## Requirements
- R1: While reset is held, and after it is released until the first verdict, `done`, `crcPass`, `codeMatch` and `accept` are all 0.
- R2: After a `start`, `done` is high for exactly one cycle. That cycle is the one that follows the clock edge accepting the 42nd valid byte (offset 41). `done` does not rise again before the next `start`.
- R3: `crcPass` is 1 only when the 16-bit value {byte 41, byte 40} equals the CRC of bytes 0 to 39. Byte 40 is the low byte. The CRC uses polynomial 0x8005 and starts from 0. Each byte is fed bit 0 first: the feedback is register bit 15 XOR the data bit, the register shifts left, and the polynomial is XORed in when the feedback is 1.
- R4: User-code bit i is taken from bit 0 of byte 8+i, for i = 0 to 31. `codeMatch` is 1 only when the assembled code equals `expectedCode`, sampled at the edge that accepts byte 41.
- R5: Bytes 0 to 7, and bits 7 to 1 of bytes 8 to 39, have no effect on `codeMatch`. They are still covered by the CRC.
- R6: `accept` equals `crcPass` AND `codeMatch`. None of the three becomes 1 except in the cycle where `done` is 1.
- R7: The verdict outputs hold their values from `done` until the next `start`. A `start` clears all of them to 0 in the following cycle.
- R8: A `start` in the middle of a header abandons it. Counting restarts at offset 0, so only the bytes after the latest `start` decide the verdict.
- R9: Cycles with `byteValid` low are ignored. Valid bytes that arrive after byte 41, or before any `start`, change neither the verdict nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new header check; aborts any check in progress |
| byteValid | input | 1 | `byteData` carries the next image byte |
| byteData | input | 8 | Image byte, in flash address order |
| expectedCode | input | 32 | User code the image must carry |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| crcPass | output | 1 | Header CRC verified |
| codeMatch | output | 1 | Embedded user code equals `expectedCode` |
| accept | output | 1 | Image accepted (CRC good and code matches) |

## Verification
On every cycle, the assertions check three things. `done` is a single-cycle pulse. `accept` stays tied to the two partial verdicts. The verdict changes only on a `done` cycle, or by being cleared after a `start`. The bench scenarios are the only way to show the arithmetic behaviour: the CRC value and byte order, the mapping of each user-code bit to its byte offset, and that the ignored bits really are ignored. The same holds for byte counting across gaps, aborts and trailing bytes.

// File: rtl/hdr_validator_pkg.sv
package hdr_validator_pkg;
  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic clear;     // restart: wipe CRC, code and verdict
    logic dataByte;  // header byte: fold into CRC
    logic codeByte;  // header byte that carries a user-code bit
    logic crcLo;     // low byte of received check value
    logic crcHi;     // high byte of received check value: decide
  } hdrStrobe_t;
endpackage

// File: rtl/hdr_validator_ctrl.sv
module hdr_validator_ctrl
  import hdr_validator_pkg::*;
#(
  parameter int HDR_BYTES  = 40,
  parameter int CODE_FIRST = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       byteValid,
  output hdrStrobe_t strb
);
  localparam int TOTAL = HDR_BYTES + 2;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] CODE_LO  = CW'(CODE_FIRST);
  localparam logic [CW-1:0] LO_IDX   = CW'(HDR_BYTES);
  localparam logic [CW-1:0] HI_IDX   = CW'(HDR_BYTES + 1);

  logic          busy;
  logic [CW-1:0] byteCount;
  logic          take;

  assign take = busy & byteValid & ~start;

  always_comb begin
    strb.clear    = start;
    strb.dataByte = take && (byteCount < LO_IDX);
    strb.codeByte = take && (byteCount >= CODE_LO) && (byteCount < LO_IDX);
    strb.crcLo    = take && (byteCount == LO_IDX);
    strb.crcHi    = take && (byteCount == HI_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      byteCount <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      byteCount <= '0;
    end else if (take) begin
      if (byteCount == HI_IDX) busy <= 1'b0;
      byteCount <= byteCount + 1'b1;
    end
  end
endmodule

// File: rtl/hdr_validator_dp.sv
module hdr_validator_dp
  import hdr_validator_pkg::*;
#(
  parameter int          CODE_BITS = 32,
  parameter logic [15:0] CRC_POLY  = 16'h8005
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  hdrStrobe_t           strb,
  input  logic [7:0]           byteData,
  input  logic [CODE_BITS-1:0] expectedCode,
  output logic                 done,
  output logic                 crcPass,
  output logic                 codeMatch,
  output logic                 accept
);
  logic [15:0]          crcReg;
  logic [15:0]          crcNext;
  logic [CODE_BITS-1:0] codeReg;
  logic [7:0]           rxLo;
  logic                 crcOk;
  logic                 codeOk;

  // Eight serial CRC steps per byte, bit 0 first.
  always_comb begin
    logic fb;
    crcNext = crcReg;
    for (int j = 0; j < 8; j++) begin
      fb      = crcNext[15] ^ byteData[j];
      crcNext = {crcNext[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
  end

  assign crcOk  = (crcReg == {byteData, rxLo});
  assign codeOk = (codeReg == expectedCode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crcReg    <= '0;
      codeReg   <= '0;
      rxLo      <= '0;
      done      <= 1'b0;
      crcPass   <= 1'b0;
      codeMatch <= 1'b0;
      accept    <= 1'b0;
    end else if (strb.clear) begin
      crcReg    <= '0;
      codeReg   <= '0;
      rxLo      <= '0;
      done      <= 1'b0;
      crcPass   <= 1'b0;
      codeMatch <= 1'b0;
      accept    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.dataByte) crcReg <= crcNext;
      if (strb.codeByte) codeReg <= {byteData[0], codeReg[CODE_BITS-1:1]};
      if (strb.crcLo) rxLo <= byteData;
      if (strb.crcHi) begin
        done      <= 1'b1;
        crcPass   <= crcOk;
        codeMatch <= codeOk;
        accept    <= crcOk & codeOk;
      end
    end
  end
endmodule

// File: rtl/hdr_validator.sv
module hdr_validator
  import hdr_validator_pkg::*;
#(
  parameter int          HDR_BYTES  = 40,
  parameter int          CODE_FIRST = 8,
  parameter logic [15:0] CRC_POLY   = 16'h8005,
  localparam int         CODE_BITS  = HDR_BYTES - CODE_FIRST
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 byteValid,
  input  logic [7:0]           byteData,
  input  logic [CODE_BITS-1:0] expectedCode,
  output logic                 done,
  output logic                 crcPass,
  output logic                 codeMatch,
  output logic                 accept
);
  hdrStrobe_t strb;

  hdr_validator_ctrl #(
    .HDR_BYTES (HDR_BYTES),
    .CODE_FIRST(CODE_FIRST)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .byteValid(byteValid),
    .strb     (strb)
  );

  hdr_validator_dp #(
    .CODE_BITS(CODE_BITS),
    .CRC_POLY (CRC_POLY)
  ) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .byteData    (byteData),
    .expectedCode(expectedCode),
    .done        (done),
    .crcPass     (crcPass),
    .codeMatch   (codeMatch),
    .accept      (accept)
  );
endmodule

// File: rtl/hdr_validator_chk.sv
module hdr_validator_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic crcPass,
  input logic codeMatch,
  input logic accept
);
  // R2: done never lasts beyond one cycle
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: accept follows the two partial verdicts
  a_r6_accept_and: assert property (@(posedge clk) disable iff (!rst_n)
    accept == (crcPass && codeMatch));

  // R6: a verdict bit can only become 1 together with done
  a_r6_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(crcPass) || $rose(codeMatch) || $rose(accept)) |-> done);

  // R7: verdict holds unless a start or a fresh done intervenes
  a_r7_verdict_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (done || $stable({crcPass, codeMatch, accept})));

  // R7, R8: start clears everything
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !crcPass && !codeMatch && !accept));
endmodule

bind hdr_validator hdr_validator_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .crcPass  (crcPass),
  .codeMatch(codeMatch),
  .accept   (accept)
);

// File: tb/test_hdr_validator.sv
module test_hdr_validator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic [31:0] expectedCode = 32'hA5C3_1E97;
  logic        done, crcPass, codeMatch, accept;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [42];

  always #4 clk = ~clk;  // 125 MHz

  hdr_validator i_hdr_validator (
    .clk(clk), .rst_n(rst_n), .start(start), .byteValid(byteValid),
    .byteData(byteData), .expectedCode(expectedCode), .done(done),
    .crcPass(crcPass), .codeMatch(codeMatch), .accept(accept)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crcOf(input int n);
    logic [15:0] c = 16'h0;
    logic fb;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++) begin
        fb = c[15] ^ img[k][j];
        c  = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0);
      end
    return c;
  endfunction

  function automatic logic [31:0] codeOfImg();
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++) v[i] = img[8+i][0];
    return v;
  endfunction

  task automatic build(input int seed, input logic [31:0] code);
    for (int k = 0; k < 40; k++) img[k] = 8'((k * 37 + seed * 11 + 5) ^ (seed >> 1));
    for (int i = 0; i < 32; i++) img[8+i][0] = code[i];
  endtask

  task automatic fixCrc();
    logic [15:0] c = crcOf(40);
    img[40] = c[7:0];
    img[41] = c[15:8];
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1; byteValid = 1'b0;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic feed(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (n == 42 && k == 41) chk(32'(done), 0, "R2 done before last byte");
      byteValid = 1'b1; byteData = img[k];
      if (gap > 0 && (k % gap) == gap - 1 && k != n - 1) begin
        @(negedge clk); byteValid = 1'b0;
      end
    end
    @(negedge clk); byteValid = 1'b0;
  endtask

  // Full header; check done timing and verdict.
  task automatic runAndCheck(input int gap, input string tag);
    logic expCrc, expCode;
    expCrc  = ({img[41], img[40]} == crcOf(40));
    expCode = (codeOfImg() == expectedCode);
    pulseStart();
    feed(42, gap);
    chk(32'(done), 1, {tag, " R2 done pulse"});
    chk(32'(crcPass), 32'(expCrc), {tag, " R3 crcPass"});
    chk(32'(codeMatch), 32'(expCode), {tag, " R4 codeMatch"});
    chk(32'(accept), 32'(expCrc & expCode), {tag, " R6 accept"});
    @(negedge clk);
    chk(32'(done), 0, {tag, " R2 done one cycle"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    chk({28'd0, done, crcPass, codeMatch, accept}, 0, "R1 in reset");
    rst_n = 1'b1;
    // R9: bytes before any start are ignored
    build(1, expectedCode); fixCrc();
    feed(42, 0);
    chk({28'd0, done, crcPass, codeMatch, accept}, 0, "R1 R9 no start");

    // Good image, several seeds and gap patterns (R9 gaps)
    for (int s = 0; s < 4; s++) begin
      build(s + 2, expectedCode); fixCrc();
      runAndCheck(s, "good");
      chk(32'(accept), 1, "R6 good accepted");
    end

    // R4: every code bit position flipped individually
    for (int i = 0; i < 32; i++) begin
      build(7, expectedCode);
      img[8+i][0] = ~img[8+i][0];
      fixCrc();
      runAndCheck(0, "R4 flip");
    end

    // R5: non-code bits changed; code still matches
    for (int k = 0; k < 8; k++) begin
      build(9, expectedCode);
      img[k] = ~img[k];
      img[8 + k * 4][1 + (k % 7)] = ~img[8 + k * 4][1 + (k % 7)];
      fixCrc();
      runAndCheck(0, "R5 ignored");
      chk(32'(codeMatch), 1, "R5 code unaffected");
    end

    // R3: corrupt each of the 16 check bits
    for (int b = 0; b < 16; b++) begin
      build(11, expectedCode); fixCrc();
      if (b < 8) img[40][b] = ~img[40][b]; else img[41][b-8] = ~img[41][b-8];
      runAndCheck(0, "R3 badcrc");
      chk(32'(crcPass), 0, "R3 corrupted crc rejected");
    end
    // R3: swapped byte order rejected when bytes differ
    build(12, expectedCode); fixCrc();
    if (img[40] != img[41]) begin
      byteData = img[40]; img[40] = img[41]; img[41] = byteData;
      runAndCheck(0, "R3 swapped");
    end

    // R9: trailing bytes after byte 41 leave verdict alone
    build(13, expectedCode); fixCrc();
    runAndCheck(0, "pre-trail");
    build(14, 32'h0); fixCrc();
    feed(42, 0);
    chk({28'd0, done, crcPass, codeMatch, accept}, 32'b0111, "R9 trailing bytes");

    // R7: start clears verdict
    pulseStart();
    chk({28'd0, done, crcPass, codeMatch, accept}, 0, "R7 start clears");

    // R8: abort partway, then a good header
    build(15, 32'h1234_5678); fixCrc();
    feed(20, 0);
    build(16, expectedCode); fixCrc();
    runAndCheck(0, "R8 abort");
    chk(32'(accept), 1, "R8 fresh header accepted");
    // R8: abort after 41 bytes, no done
    pulseStart();
    feed(41, 0);
    pulseStart();
    feed(1, 0);
    chk(32'(done), 0, "R8 no done after restart");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule